// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides, in the same cycle, whether a memory access may proceed. It holds sixteen protection entries. Each entry has an 8-bit configuration byte and a 32-bit address register. The configuration bytes are packed four to a 32-bit configuration word, and simple write ports update the words and the address registers.

For each access, the block takes a byte address, a length in bytes, an access type and the current privilege level, and it drives a single allow/deny result. An access that spans several 4-byte granules is tested granule by granule, and a rule applies only when it covers all of them. Lock bits freeze entries until reset, so that machine-mode software can set up rules that it cannot later relax by mistake.

Top module: `pmp_checker`

## Requirements
- R1: After reset every configuration byte and address register is zero, so every access of any type is allowed at any privilege.
- R2: Entry i uses byte i%4 of configuration word i/4 (bits 8*(i%4)+7 down to 8*(i%4)). Within a byte, bit 0 is read permission, bit 1 is write permission, bit 2 is execute permission, bits 4:3 select the matching mode (0 off, 1 top-of-range, 2 single granule, 3 naturally aligned power-of-two region) and bit 7 is the lock. A write takes effect from the cycle after the clock edge that captures it.
- R3: Address registers hold byte address bits 33:2, so matching works on the granule number g = address >> 2. In top-of-range mode, entry i matches when addr_reg[i-1] <= g < addr_reg[i], compared unsigned. Entry 0 uses a lower bound of 0.
- R4: In single-granule mode an entry matches only when g equals its address register. In power-of-two mode, an address register with n trailing one bits describes a region of 2^(n+1) granules, aligned to its own size, and a granule matches when it lies inside that region.
- R5: The access covers sectors at address + 4k for k = 0 and for every k with 4k < length, up to 4 sectors. When the deciding entry matches some sectors but not all of them, the access is denied at every privilege.
- R6: The lowest-numbered enabled entry that matches at least one sector decides the result, whatever the higher-numbered entries say.
- R7: Below machine mode (privilege code other than 3), a fully matched entry allows type 0 (read) when bit 0 is set, type 1 (write) when bit 1 is set and type 2 (execute) when bit 2 is set. It always denies type 3.
- R8: At privilege 3 (machine), a fully matched entry that is unlocked allows any access. A locked entry applies its permission bits exactly as in R7.
- R9: When no entry matches, the access is allowed if every entry's mode is off. Otherwise it is allowed only at privilege 3.
- R10: A locked entry ignores writes to its configuration byte and to its address register, while the other bytes of the same configuration word still take the written value.
- R11: While entry i+1 is locked and in top-of-range mode, writes to address register i are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the register-write ports |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for a configuration word |
| cfg_idx_i | input | 2 | Configuration word index |
| cfg_wdata_i | input | 32 | Configuration word write data |
| addr_we_i | input | 1 | Write strobe for an address register |
| addr_idx_i | input | 4 | Address register index |
| addr_wdata_i | input | 32 | Address register write data (byte address >> 2) |
| chk_addr_i | input | 32 | Byte address of the access |
| chk_len_i | input | 5 | Access length in bytes (0 to 16) |
| chk_type_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| chk_priv_i | input | 2 | Current privilege, 3 is machine mode |
| allow_o | output | 1 | 1 grants the access, 0 denies it |

## Verification
The allow result is a pure function of the access inputs and the stored entries, so it is due in the same cycle as the access. Register writes change it from the cycle after the capturing edge onward. The bench drives all inputs one nanosecond after a rising edge and samples allow_o on the following falling edge, where the behavioural model has applied the same writes at the same edge. Hand-computed checks of priority, partial matches and locking use the same sampling point, placed after the write task has returned.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } pmp_mode_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } pmp_acc_e;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  typedef struct packed {
    logic      lock;
    logic [1:0] rsvd;
    pmp_mode_e mode;
    logic      x;
    logic      w;
    logic      r;
  } pmp_cfg_t;

endpackage

// File: rtl/pmp_regs.sv
module pmp_regs
  import pmp_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned XLEN        = 32,
  localparam int unsigned CFG_REGS   = NUM_ENTRIES / 4,
  localparam int unsigned CFG_IDX_W  = $clog2(CFG_REGS),
  localparam int unsigned ENT_IDX_W  = $clog2(NUM_ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CFG_IDX_W-1:0] cfg_idx_i,
  input  logic [31:0]          cfg_wdata_i,
  input  logic                 addr_we_i,
  input  logic [ENT_IDX_W-1:0] addr_idx_i,
  input  logic [XLEN-1:0]      addr_wdata_i,
  output pmp_cfg_t             cfg_o  [NUM_ENTRIES],
  output logic [XLEN-1:0]      addr_o [NUM_ENTRIES]
);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    localparam int unsigned WORD = e / 4;
    localparam int unsigned BYTE = e % 4;

    pmp_cfg_t          cfg_r;
    logic [XLEN-1:0]   addr_r;
    logic              addr_frozen;

    // a locked TOR entry also guards the base it reads from the entry below
    if (e + 1 < NUM_ENTRIES) begin : g_guard
      assign addr_frozen = cfg_r.lock |
                           (cfg_o[e+1].lock && cfg_o[e+1].mode == MODE_TOR);
    end else begin : g_last
      assign addr_frozen = cfg_r.lock;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_r <= '0;
      end else if (cfg_we_i && cfg_idx_i == CFG_IDX_W'(WORD) && !cfg_r.lock) begin
        cfg_r <= pmp_cfg_t'(cfg_wdata_i[8*BYTE +: 8]);
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_r <= '0;
      end else if (addr_we_i && addr_idx_i == ENT_IDX_W'(e) && !addr_frozen) begin
        addr_r <= addr_wdata_i;
      end
    end

    assign cfg_o[e]  = cfg_r;
    assign addr_o[e] = addr_r;
  end

endmodule

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
  import pmp_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned MAX_SECTORS = 4
) (
  input  pmp_cfg_t              cfg_i,
  input  logic [XLEN-1:0]       top_i,
  input  logic [XLEN-1:0]       base_i,
  input  logic [XLEN-1:0]       gran_i [MAX_SECTORS],
  input  logic [MAX_SECTORS-1:0] sect_en_i,
  output logic                  any_o,
  output logic                  all_o
);

  logic [XLEN:0]   seed;
  logic [XLEN:0]   low_ones;
  logic [XLEN-1:0] cmp_mask;
  logic [MAX_SECTORS-1:0] hit;

  // trailing ones of {addr,1} (NAPOT) or {addr,0} (NA4) are don't-care granule bits
  assign seed     = {top_i, cfg_i.mode == MODE_NAPOT};
  assign low_ones = seed & ~(seed + 1'b1);
  assign cmp_mask = ~low_ones[XLEN-1:0];

  for (genvar k = 0; k < MAX_SECTORS; k++) begin : g_sect
    logic tor_hit;
    logic pow_hit;
    assign tor_hit = (base_i <= gran_i[k]) && (gran_i[k] < top_i);
    assign pow_hit = ((gran_i[k] ^ top_i) & cmp_mask) == '0;
    always_comb begin
      unique case (cfg_i.mode)
        MODE_TOR:              hit[k] = tor_hit;
        MODE_NA4, MODE_NAPOT:  hit[k] = pow_hit;
        default:               hit[k] = 1'b0;
      endcase
    end
  end

  assign any_o = |(hit & sect_en_i);
  assign all_o = &(hit | ~sect_en_i);

endmodule

// File: rtl/pmp_arbiter.sv
module pmp_arbiter #(
  parameter int unsigned NUM_ENTRIES = 16
) (
  input  logic [NUM_ENTRIES-1:0] any_i,
  input  logic [NUM_ENTRIES-1:0] all_i,
  input  logic [NUM_ENTRIES-1:0] active_i,
  input  logic [NUM_ENTRIES-1:0] perm_i,
  input  logic [NUM_ENTRIES-1:0] lock_i,
  input  logic                   machine_i,
  output logic                   allow_o
);

  always_comb begin
    logic found;
    found   = 1'b0;
    allow_o = machine_i | ~|active_i;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!found && any_i[i]) begin
        found   = 1'b1;
        allow_o = all_i[i] & ((machine_i & ~lock_i[i]) | perm_i[i]);
      end
    end
  end

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned XLEN        = 32,
  parameter int unsigned MAX_SECTORS = 4,
  localparam int unsigned CFG_IDX_W  = $clog2(NUM_ENTRIES / 4),
  localparam int unsigned ENT_IDX_W  = $clog2(NUM_ENTRIES),
  localparam int unsigned LEN_W      = $clog2(4 * MAX_SECTORS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CFG_IDX_W-1:0] cfg_idx_i,
  input  logic [31:0]          cfg_wdata_i,
  input  logic                 addr_we_i,
  input  logic [ENT_IDX_W-1:0] addr_idx_i,
  input  logic [XLEN-1:0]      addr_wdata_i,
  input  logic [XLEN-1:0]      chk_addr_i,
  input  logic [LEN_W-1:0]     chk_len_i,
  input  logic [1:0]           chk_type_i,
  input  logic [1:0]           chk_priv_i,
  output logic                 allow_o
);

  pmp_cfg_t         cfg_q  [NUM_ENTRIES];
  logic [XLEN-1:0]  addr_q [NUM_ENTRIES];
  logic [XLEN-1:0]  sect_gran [MAX_SECTORS];
  logic [MAX_SECTORS-1:0] sect_en;
  logic [NUM_ENTRIES-1:0] hit_any, hit_all, active, perm, lock;

  pmp_regs #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .XLEN       (XLEN)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_wdata_i (cfg_wdata_i),
    .addr_we_i   (addr_we_i),
    .addr_idx_i  (addr_idx_i),
    .addr_wdata_i(addr_wdata_i),
    .cfg_o       (cfg_q),
    .addr_o      (addr_q)
  );

  for (genvar k = 0; k < MAX_SECTORS; k++) begin : g_sect
    logic [XLEN-1:0] sect_addr;
    assign sect_addr    = chk_addr_i + XLEN'(4 * k);
    assign sect_gran[k] = {2'b00, sect_addr[XLEN-1:2]};
    if (k == 0) begin : g_first
      assign sect_en[k] = 1'b1;
    end else begin : g_more
      assign sect_en[k] = chk_len_i > LEN_W'(4 * k);
    end
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    logic [XLEN-1:0] base;
    if (e == 0) begin : g_zero
      assign base = '0;
    end else begin : g_prev
      assign base = addr_q[e-1];
    end

    pmp_entry_match #(
      .XLEN       (XLEN),
      .MAX_SECTORS(MAX_SECTORS)
    ) u_match (
      .cfg_i    (cfg_q[e]),
      .top_i    (addr_q[e]),
      .base_i   (base),
      .gran_i   (sect_gran),
      .sect_en_i(sect_en),
      .any_o    (hit_any[e]),
      .all_o    (hit_all[e])
    );

    assign active[e] = cfg_q[e].mode != MODE_OFF;
    assign lock[e]   = cfg_q[e].lock;
    assign perm[e]   = (chk_type_i == ACC_READ)  ? cfg_q[e].r :
                       (chk_type_i == ACC_WRITE) ? cfg_q[e].w :
                       (chk_type_i == ACC_EXEC)  ? cfg_q[e].x : 1'b0;
  end

  pmp_arbiter #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_arb (
    .any_i    (hit_any),
    .all_i    (hit_all),
    .active_i (active),
    .perm_i   (perm),
    .lock_i   (lock),
    .machine_i(chk_priv_i == PRIV_MACHINE),
    .allow_o  (allow_o)
  );

endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva
  import pmp_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned XLEN        = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [1:0]             chk_priv_i,
  input logic                   allow_o,
  input pmp_cfg_t               cfg_i  [NUM_ENTRIES],
  input logic [XLEN-1:0]        addr_i [NUM_ENTRIES],
  input logic [NUM_ENTRIES-1:0] any_i,
  input logic [NUM_ENTRIES-1:0] all_i
);

  logic any_on;
  always_comb begin
    any_on = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) any_on |= (cfg_i[i].mode != MODE_OFF);
  end

  a_r1_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(allow_o));

  a_r9_idle_allows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_on |-> allow_o);

  a_r9_machine_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_priv_i == PRIV_MACHINE && any_i == '0) |-> allow_o);

  a_r5_partial_deny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_i[0] && !all_i[0]) |-> !allow_o);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_lock
    a_r10_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_i[e].lock |=> $stable(cfg_i[e]));
    a_r10_addr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_i[e].lock |=> $stable(addr_i[e]));
    if (e + 1 < NUM_ENTRIES) begin : g_tor
      a_r11_tor_base_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_i[e+1].lock && cfg_i[e+1].mode == MODE_TOR) |=> $stable(addr_i[e]));
    end
  end

endmodule

bind pmp_checker pmp_checker_sva #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .XLEN       (XLEN)
) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .chk_priv_i(chk_priv_i),
  .allow_o   (allow_o),
  .cfg_i     (cfg_q),
  .addr_i    (addr_q),
  .any_i     (hit_any),
  .all_i     (hit_all)
);

// File: tb/pmp_checker_bench.sv
module pmp_checker_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        addr_we = 1'b0;
  logic [3:0]  addr_idx = '0;
  logic [31:0] addr_wdata = '0;
  logic [31:0] chk_addr = '0;
  logic [4:0]  chk_len = 5'd4;
  logic [1:0]  chk_type = '0;
  logic [1:0]  chk_priv = '0;
  logic        allow_o;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;

  logic [7:0]  m_cfg  [16];
  logic [31:0] m_addr [16];

  always #2 clk_i = ~clk_i;

  pmp_checker u_pmp_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we),
    .cfg_idx_i   (cfg_idx),
    .cfg_wdata_i (cfg_wdata),
    .addr_we_i   (addr_we),
    .addr_idx_i  (addr_idx),
    .addr_wdata_i(addr_wdata),
    .chk_addr_i  (chk_addr),
    .chk_len_i   (chk_len),
    .chk_type_i  (chk_type),
    .chk_priv_i  (chk_priv),
    .allow_o     (allow_o)
  );

  // behavioural register state
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 16; i++) begin
        m_cfg[i]  = '0;
        m_addr[i] = '0;
      end
    end else begin
      bit blk;
      blk = 1'b0;
      if (addr_we) begin
        blk = m_cfg[addr_idx][7];
        if (addr_idx < 15 && m_cfg[addr_idx+1][7] && m_cfg[addr_idx+1][4:3] == 2'd1) blk = 1'b1;
      end
      if (cfg_we)
        for (int b = 0; b < 4; b++)
          if (!m_cfg[cfg_idx*4+b][7]) m_cfg[cfg_idx*4+b] = cfg_wdata[8*b +: 8];
      if (addr_we && !blk) m_addr[addr_idx] = addr_wdata;
    end
  end

  function automatic bit ref_allow(logic [31:0] a, int len, int t, int p);
    bit any_on = 1'b0;
    for (int e = 0; e < 16; e++) if (m_cfg[e][4:3] != 2'd0) any_on = 1'b1;
    for (int e = 0; e < 16; e++) begin
      int mode = int'(m_cfg[e][4:3]);
      int hits = 0;
      int tests = 0;
      if (mode == 0) continue;
      for (int k = 0; k < 4; k++) begin
        longint g;
        longint lo;
        bit m;
        if (k > 0 && len <= 4 * k) break;
        tests++;
        g  = longint'((a + 32'(4 * k)) >> 2);
        lo = (e == 0) ? 64'd0 : longint'(m_addr[(e == 0) ? 0 : e - 1]);
        if (mode == 1) m = (g >= lo) && (g < longint'(m_addr[e]));
        else if (mode == 2) m = (g == longint'(m_addr[e]));
        else begin
          int n = 0;
          longint sz;
          while (n < 32 && m_addr[e][n]) n++;
          sz = longint'(1) << (n + 1);
          m = (g & ~(sz - 1)) == (longint'(m_addr[e]) & ~(sz - 1));
        end
        if (m) hits++;
      end
      if (hits == 0) continue;
      if (hits != tests) return 1'b0;
      if (p == 3 && !m_cfg[e][7]) return 1'b1;
      return (t < 3) ? m_cfg[e][t] : 1'b0;
    end
    return !any_on || p == 3;
  endfunction

  // model comparison on every clock, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && cmp_on) begin
      bit exp;
      exp = ref_allow(chk_addr, int'(chk_len), int'(chk_type), int'(chk_priv));
      checks++;
      if (allow_o !== exp) begin
        fails++;
        $display("FAIL model R1..R11 addr=%h len=%0d type=%0d priv=%0d: allow_o=%0b expected %0b",
                 chk_addr, chk_len, chk_type, chk_priv, allow_o, exp);
      end
    end
  end

  task automatic wr_cfg(int idx, logic [31:0] d);
    @(posedge clk_i); #1;
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = d;
    @(posedge clk_i); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wr_addr(int idx, logic [31:0] d);
    @(posedge clk_i); #1;
    addr_we = 1'b1; addr_idx = 4'(idx); addr_wdata = d;
    @(posedge clk_i); #1;
    addr_we = 1'b0;
  endtask

  task automatic probe(logic [31:0] a, int len, int t, int p, bit exp, string tag);
    @(posedge clk_i); #1;
    chk_addr = a; chk_len = 5'(len); chk_type = 2'(t); chk_priv = 2'(p);
    @(negedge clk_i);
    checks++;
    if (allow_o !== exp) begin
      fails++;
      $display("FAIL %s addr=%h len=%0d type=%0d priv=%0d: allow_o=%0b expected %0b",
               tag, a, len, t, p, allow_o, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk_i); #1;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    cmp_on = 1'b1;

    // R1: reset state grants everything
    probe(32'h0000_1000, 4, 0, 0, 1'b1, "R1 user read after reset");
    probe(32'hFFFF_FFF0, 16, 2, 1, 1'b1, "R1 user exec after reset");

    // random phase, locks kept clear; checked against the model every clock
    for (int n = 0; n < 1500; n++) begin
      int op = int'($urandom_range(0, 3));
      if (op == 0) wr_cfg(int'($urandom_range(0, 3)), $urandom() & 32'h7F7F_7F7F);
      else if (op == 1) wr_addr(int'($urandom_range(0, 15)), $urandom_range(0, 32'h0BFF));
      else begin
        @(posedge clk_i); #1;
        chk_addr = $urandom_range(0, 32'h2FFF);
        chk_len  = 5'($urandom_range(0, 16));
        chk_type = 2'($urandom_range(0, 3));
        chk_priv = 2'($urandom_range(0, 3));
        @(negedge clk_i);
      end
    end

    // clean slate
    for (int w = 0; w < 4; w++) wr_cfg(w, 32'h0);
    probe(32'h0000_1000, 4, 1, 0, 1'b1, "R9 all entries off");

    // R2/R4: entry 0 NAPOT 64-byte region at 0x8000_0000, read only
    wr_addr(0, 32'h2000_0007);
    wr_cfg(0, 32'h0000_0019);
    probe(32'h8000_0010, 4, 0, 0, 1'b1, "R4 napot read inside");
    probe(32'h8000_0010, 4, 1, 0, 1'b0, "R7 napot write without W");
    probe(32'h8000_0040, 4, 0, 0, 1'b0, "R9 user unmatched denied");
    probe(32'h8000_0040, 4, 1, 3, 1'b1, "R9 machine unmatched allowed");
    probe(32'h8000_0010, 4, 1, 3, 1'b1, "R8 machine unlocked bypass");
    probe(32'h8000_003C, 4, 0, 0, 1'b1, "R5 single sector at edge");
    probe(32'h8000_003C, 8, 0, 0, 1'b0, "R5 partial user");
    probe(32'h8000_003C, 8, 0, 3, 1'b0, "R5 partial machine");

    // R3/R6: entry 1 NA4 W at 0x1000, entry 2 TOR X|R over 0x1000..0x1FFF
    wr_addr(1, 32'h0000_0400);
    wr_addr(2, 32'h0000_0800);
    wr_cfg(0, 32'h000D_1219);
    probe(32'h0000_1004, 4, 2, 0, 1'b1, "R3 tor lower part");
    probe(32'h0000_1FFC, 4, 2, 0, 1'b1, "R3 tor last granule");
    probe(32'h0000_2000, 4, 2, 0, 1'b0, "R3 tor top excluded");
    probe(32'h0000_0FFC, 4, 2, 0, 1'b0, "R3 below tor base");
    probe(32'h0000_1000, 4, 2, 0, 1'b0, "R6 lower entry wins");
    probe(32'h0000_1000, 4, 1, 0, 1'b1, "R4 na4 write");
    probe(32'h0000_1004, 4, 1, 0, 1'b0, "R7 tor write without W");
    probe(32'h0000_1004, 4, 0, 0, 1'b1, "R7 tor read");
    probe(32'h0000_1004, 4, 3, 0, 1'b0, "R7 reserved type");

    // R8: lock entry 2
    wr_cfg(0, 32'h008D_1219);
    probe(32'h0000_1800, 4, 1, 3, 1'b0, "R8 locked write denied in machine");
    probe(32'h0000_1800, 4, 2, 3, 1'b1, "R8 locked exec allowed in machine");
    probe(32'h0000_1000, 4, 1, 3, 1'b1, "R8 unlocked entry machine bypass");

    // R10: locked byte survives, others cleared
    wr_cfg(0, 32'h0000_0000);
    probe(32'h0000_1800, 4, 2, 0, 1'b1, "R10 locked cfg byte kept");
    probe(32'h8000_0010, 4, 0, 0, 1'b0, "R10 unlocked byte cleared");
    wr_addr(2, 32'h0000_0600);
    probe(32'h0000_1FFC, 4, 2, 0, 1'b1, "R10 locked addr kept");
    // R11: base of locked TOR entry frozen
    wr_addr(1, 32'h0000_0700);
    probe(32'h0000_1004, 4, 2, 0, 1'b1, "R11 tor base kept");

    // R1 again: reset clears locks
    cmp_on = 1'b0;
    do_reset();
    cmp_on = 1'b1;
    probe(32'h0000_1800, 4, 1, 0, 1'b1, "R1 reset clears locked entry");

    cmp_on = 1'b0;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule